// File: doc/BRIEF.md
# Dual 16-bit Period Timer with 32-bit Cascade

This block holds two up-counting timers for a peripheral bus. Each timer has a control register, a counter register and a period register. Each also has a sticky match flag and an interrupt request. A timer counts either the internal clock or rising edges on its own external count input, after a programmable prescaler. When a tick finds the counter equal to its period, the counter returns to zero and the flag is raised.

A cascade bit in the lower timer's control register fuses the pair into one 32-bit timer. The two counters form one 32-bit count with the upper timer's counter as the high half, and the two periods form one 32-bit period in the same way. In this mode the lower timer's control settings drive everything, and a match raises the upper timer's flag. Software reaches the registers through a single-cycle write port and a combinational read port.

Top module: `tmr_pair`

## Requirements
- R1: After reset the control registers, counters and flags read 0, and both period registers read all ones.
- R2: Every prescaled tick either increments the counter or, if the counter already equals the period, clears it to 0 and sets the flag. A period of P therefore spans P+1 ticks.
- R3: Control bits 6:4 select the prescale ratio. Codes 0 to 7 map to 1, 2, 4, 8, 16, 32, 64 and 256 count events per tick.
- R4: Control bit 15 enables the timer. While it is clear, the counter and the prescaler hold their values.
- R5: Control bit 1 selects the external count input. The input passes through two synchronizing flops, and each rising edge yields exactly one count event. That event is consumed at the third rising clock edge at which the high level is present, the capturing edge being the first.
- R6: The flag stays set until a write to register code 3 with data bit 0 high clears it. If the same cycle brings a match, the match wins and the flag stays set.
- R7: irq_o of a timer equals its flag ANDed with control bit 2 of the governing control register.
- R8: Control bit 3 of timer 0 cascades the pair. Timer 0's enable, prescale, source (using ext_i[0]) and interrupt-enable bits govern the 32-bit counter {count1,count0} against {period1,period0}. A match sets only flag 1, and timer 1's control register has no effect.
- R9: A write to the counter register loads the value, overrides a same-cycle tick and restarts the owning prescaler. In cascade mode the owning prescaler is timer 0's, for either half.
- R10: Register codes are 0 control, 1 counter, 2 period and 3 flag; the flag register reads the flag in bit 0. Control reads back only bits 15, 6:4, 2 and 1, plus bit 3 on timer 0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_i | input | 2 | Asynchronous external count inputs, one per timer |
| wr_en | input | 1 | Register write strobe |
| wr_unit | input | 1 | Timer addressed by the write |
| wr_reg | input | 2 | Register code of the write |
| wr_data | input | 16 | Write data |
| rd_unit | input | 1 | Timer addressed by the read |
| rd_reg | input | 2 | Register code of the read |
| rd_data | output | 16 | Read data, combinational |
| flag_o | output | 2 | Sticky match flags |
| irq_o | output | 2 | Interrupt requests |

## Verification
The assertions assume the write port carries at most one register access per cycle and that reset is held for several clock edges, so the history that $past relies on starts from reset values. They also assume that external count inputs are held steady for at least one clock period per level; the edge detector cannot represent narrower pulses. The stimulus drives every input at the falling clock edge. It keeps external pulses at least two cycles high and two cycles low, and it never issues writes on consecutive cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTL_EN     = 15;
    localparam int CTL_PS_LSB = 4;
    localparam int CTL_CAS    = 3;
    localparam int CTL_IE     = 2;
    localparam int CTL_EXT    = 1;
    localparam int PS_W       = 8;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_COUNT  = 2'd1,
        REG_PERIOD = 2'd2,
        REG_FLAG   = 2'd3
    } tmr_reg_e;

    typedef struct packed {
        logic       en;
        logic [2:0] ps;
        logic       cas;
        logic       ie;
        logic       ext;
    } tmr_ctrl_t;

    // Count events per tick for each prescale code
    function automatic logic [PS_W:0] ps_ratio(input logic [2:0] code);
        logic [PS_W:0] r;
        case (code)
            3'd0: r = 9'd1;
            3'd1: r = 9'd2;
            3'd2: r = 9'd4;
            3'd3: r = 9'd8;
            3'd4: r = 9'd16;
            3'd5: r = 9'd32;
            3'd6: r = 9'd64;
            default: r = 9'd256;
        endcase
        return r;
    endfunction

    function automatic tmr_ctrl_t ctrl_unpack(input logic [15:0] v, input logic allow_cas);
        tmr_ctrl_t c;
        c.en  = v[CTL_EN];
        c.ps  = v[CTL_PS_LSB +: 3];
        c.cas = v[CTL_CAS] & allow_cas;
        c.ie  = v[CTL_IE];
        c.ext = v[CTL_EXT];
        return c;
    endfunction

    function automatic logic [15:0] ctrl_pack(input tmr_ctrl_t c);
        logic [15:0] v;
        v = '0;
        v[CTL_EN]            = c.en;
        v[CTL_PS_LSB +: 3]   = c.ps;
        v[CTL_CAS]           = c.cas;
        v[CTL_IE]            = c.ie;
        v[CTL_EXT]           = c.ext;
        return v;
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] pulse_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = async_i;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign pulse_o = sy_q.s2 & ~sy_q.s3;

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o[g] |=> !pulse_o[g]); // R5
    end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       step_i,
    input  logic       restart_i,
    input  logic [2:0] code_i,
    output logic       tick_o
);

    logic [PS_W-1:0] pc_d, pc_q;
    logic [PS_W:0]   last;

    always_comb begin
        last   = ps_ratio(code_i) - 9'd1;
        tick_o = run_i && step_i && ({1'b0, pc_q} >= last);
        pc_d   = pc_q;
        if (restart_i)              pc_d = '0;
        else if (run_i && step_i)   pc_d = tick_o ? '0 : pc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    AST_PS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> $stable(pc_q)); // R4

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   ext_i,
    input  logic         wr_en,
    input  logic         wr_unit,
    input  logic [1:0]   wr_reg,
    input  logic [W-1:0] wr_data,
    input  logic         rd_unit,
    input  logic [1:0]   rd_reg,
    output logic [W-1:0] rd_data,
    output logic [1:0]   flag_o,
    output logic [1:0]   irq_o
);

    localparam int DW = 2 * W;

    typedef struct packed {
        tmr_ctrl_t [1:0]       ctrl;
        logic [1:0][W-1:0]     cnt;
        logic [1:0][W-1:0]     per;
        logic [1:0]            flag;
    } state_t;

    state_t   st_d, st_q;
    logic     cas;
    logic     cnt_wr;
    logic [1:0] pulse, tick, run, step, restart;
    logic [DW-1:0] cat_cnt, cat_per;
    tmr_reg_e wsel, rsel;

    assign wsel   = tmr_reg_e'(wr_reg);
    assign rsel   = tmr_reg_e'(rd_reg);
    assign cas    = st_q.ctrl[0].cas;
    assign cnt_wr = wr_en && (wsel == REG_COUNT);

    tmr_edge_sync #(.N(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_i),
        .pulse_o (pulse)
    );

    // Timer 0 settings govern the pair when cascaded
    always_comb begin
        run[0]     = st_q.ctrl[0].en;
        step[0]    = st_q.ctrl[0].ext ? pulse[0] : 1'b1;
        restart[0] = cnt_wr && (cas || !wr_unit);
        run[1]     = !cas && st_q.ctrl[1].en;
        step[1]    = st_q.ctrl[1].ext ? pulse[1] : 1'b1;
        restart[1] = cnt_wr && !cas && wr_unit;
    end

    for (genvar u = 0; u < 2; u++) begin : g_ps
        tmr_prescale u_ps (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (run[u]),
            .step_i    (step[u]),
            .restart_i (restart[u]),
            .code_i    (st_q.ctrl[u].ps),
            .tick_o    (tick[u])
        );
    end

    always_comb begin
        st_d    = st_q;
        cat_cnt = {st_q.cnt[1], st_q.cnt[0]};
        cat_per = {st_q.per[1], st_q.per[0]};

        if (wr_en && wsel == REG_FLAG && wr_data[0])
            st_d.flag[wr_unit] = 1'b0;

        if (cas) begin
            if (tick[0]) begin
                if (cat_cnt == cat_per) begin
                    st_d.cnt     = '0;
                    st_d.flag[1] = 1'b1;
                end else begin
                    {st_d.cnt[1], st_d.cnt[0]} = cat_cnt + DW'(1);
                end
            end
        end else begin
            for (int u = 0; u < 2; u++) begin
                if (tick[u]) begin
                    if (st_q.cnt[u] == st_q.per[u]) begin
                        st_d.cnt[u]  = '0;
                        st_d.flag[u] = 1'b1;
                    end else begin
                        st_d.cnt[u] = st_q.cnt[u] + W'(1);
                    end
                end
            end
        end

        if (wr_en) begin
            case (wsel)
                REG_CTRL:   st_d.ctrl[wr_unit] = ctrl_unpack(wr_data[15:0], !wr_unit);
                REG_COUNT:  st_d.cnt[wr_unit]  = wr_data;
                REG_PERIOD: st_d.per[wr_unit]  = wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= '0;
            st_q.cnt  <= '0;
            st_q.per  <= '1;
            st_q.flag <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rsel)
            REG_CTRL:   rd_data = W'(ctrl_pack(st_q.ctrl[rd_unit]));
            REG_COUNT:  rd_data = st_q.cnt[rd_unit];
            REG_PERIOD: rd_data = st_q.per[rd_unit];
            default:    rd_data = W'(st_q.flag[rd_unit]);
        endcase
    end

    assign flag_o   = st_q.flag;
    assign irq_o[0] = st_q.flag[0] & st_q.ctrl[0].ie;
    assign irq_o[1] = st_q.flag[1] & (cas ? st_q.ctrl[0].ie : st_q.ctrl[1].ie);

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas && tick[0] && st_q.cnt[0] == st_q.per[0] && !restart[0])
        |=> (st_q.cnt[0] == '0 && st_q.flag[0])); // R2

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas && !st_q.ctrl[0].en && !restart[0]) |=> $stable(st_q.cnt[0])); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o[1] && !(wr_en && wsel == REG_FLAG && wr_unit && wr_data[0]))
        |=> flag_o[1]); // R6

    AST_CAS_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cas && !flag_o[0]) |=> !flag_o[0]); // R8

endmodule

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_i = '0;
    logic        wr_en = 1'b0;
    logic        wr_unit = 1'b0;
    logic [1:0]  wr_reg = '0;
    logic [15:0] wr_data = '0;
    logic        rd_unit = 1'b0;
    logic [1:0]  rd_reg = '0;
    logic [15:0] rd_data;
    logic [1:0]  flag_o, irq_o;

    int checks = 0;
    int errors = 0;
    string req = "R1";

    always #10 clk = ~clk;

    tmr_pair u_tmr_pair (
        .clk(clk), .rst_n(rst_n), .ext_i(ext_i),
        .wr_en(wr_en), .wr_unit(wr_unit), .wr_reg(wr_reg), .wr_data(wr_data),
        .rd_unit(rd_unit), .rd_reg(rd_reg), .rd_data(rd_data),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    // Behavioural reference model
    bit m_en[2], m_ie[2], m_ext[2], m_flag[2], m_cas;
    int m_ps[2], m_cnt[2], m_per[2], m_pc[2];
    bit m_s1[2], m_s2[2], m_s3[2];

    function automatic int ratio(int code);
        return (code == 7) ? 256 : (1 << code);  // R3
    endfunction

    function automatic int exp_read(int u, int r);
        case (r)
            0: return (int'(m_en[u]) << 15) | (m_ps[u] << 4) |
                      ((u == 0 ? int'(m_cas) : 0) << 3) | (int'(m_ie[u]) << 2) | (int'(m_ext[u]) << 1);
            1: return m_cnt[u];
            2: return m_per[u];
            default: return int'(m_flag[u]);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int u = 0; u < 2; u++) begin
                m_en[u] = 0; m_ie[u] = 0; m_ext[u] = 0; m_flag[u] = 0;
                m_ps[u] = 0; m_cnt[u] = 0; m_per[u] = 16'hFFFF; m_pc[u] = 0;
                m_s1[u] = 0; m_s2[u] = 0; m_s3[u] = 0;
            end
            m_cas = 0;
        end else begin
            bit tk[2];
            bit nf[2];
            bit old_cas;
            old_cas = m_cas;
            for (int u = 0; u < 2; u++) begin
                bit ev;
                tk[u] = 0;
                nf[u] = m_flag[u];
                ev = m_ext[u] ? (m_s2[u] && !m_s3[u]) : 1'b1;
                if ((u == 0 || !old_cas) && m_en[u] && ev) begin
                    if (m_pc[u] >= ratio(m_ps[u]) - 1) begin tk[u] = 1; m_pc[u] = 0; end
                    else m_pc[u]++;
                end
            end
            if (wr_en && wr_reg == 2'd3 && wr_data[0]) nf[wr_unit] = 0;   // R6
            if (old_cas) begin
                if (tk[0]) begin
                    longint c32, p32;
                    c32 = longint'(m_cnt[1]) * 65536 + m_cnt[0];
                    p32 = longint'(m_per[1]) * 65536 + m_per[0];
                    if (c32 == p32) begin m_cnt[0] = 0; m_cnt[1] = 0; nf[1] = 1; end
                    else begin
                        c32++;
                        m_cnt[0] = int'(c32 % 65536);
                        m_cnt[1] = int'((c32 / 65536) % 65536);
                    end
                end
            end else begin
                for (int u = 0; u < 2; u++)
                    if (tk[u]) begin
                        if (m_cnt[u] == m_per[u]) begin m_cnt[u] = 0; nf[u] = 1; end
                        else m_cnt[u] = (m_cnt[u] + 1) % 65536;
                    end
            end
            if (wr_en) begin
                int u;
                u = int'(wr_unit);
                case (wr_reg)
                    2'd0: begin
                        m_en[u] = wr_data[15]; m_ps[u] = int'(wr_data[6:4]);
                        m_ie[u] = wr_data[2];  m_ext[u] = wr_data[1];
                        if (u == 0) m_cas = wr_data[3];
                    end
                    2'd1: begin
                        m_cnt[u] = int'(wr_data);
                        m_pc[old_cas ? 0 : u] = 0;   // R9
                    end
                    2'd2: m_per[u] = int'(wr_data);
                    default: ;
                endcase
            end
            m_flag = nf;
            for (int u = 0; u < 2; u++) begin
                m_s3[u] = m_s2[u]; m_s2[u] = m_s1[u]; m_s1[u] = ext_i[u];
            end
        end
    end

    // Compare every cycle at the falling edge, rotating the read selection
    always @(negedge clk) begin
        if (rst_n) begin
            int u, r, ex;
            bit ei;
            u = int'(rd_unit); r = int'(rd_reg);
            ex = exp_read(u, r);
            checks++;
            if (int'(rd_data) != ex) begin
                errors++;
                $display("FAIL %s: unit %0d reg %0d read %h expected %h", req, u, r, rd_data, ex[15:0]);
            end
            checks++;
            if (flag_o != {m_flag[1], m_flag[0]}) begin
                errors++;
                $display("FAIL %s: flags %b expected %b", req, flag_o, {m_flag[1], m_flag[0]});
            end
            checks++;
            for (int k = 0; k < 2; k++) begin
                bit ie;
                ie = (k == 1 && m_cas) ? m_ie[0] : m_ie[k];
                ei = m_flag[k] && ie;
                if (irq_o[k] != ei) begin
                    errors++;
                    $display("FAIL R7: irq[%0d] %b expected %b", k, irq_o[k], ei);
                end
            end
            {rd_unit, rd_reg} <= {rd_unit, rd_reg} + 3'd1;
        end
    end

    task automatic wr(input int u, input int r, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_unit = u[0]; wr_reg = r[1:0]; wr_data = v[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_pulses(input int u, input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_i[u] = 1'b1;
            idle(hi);
            ext_i[u] = 1'b0;
            idle(lo);
        end
    endtask

    task automatic finish_run;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        req = "R1"; idle(16);                      // R1 reset values read back
        req = "R2"; wr(0, 2, 5); wr(0, 0, 16'h8004); idle(40);   // R2 wrap and flag
        req = "R6"; wr(0, 3, 1); idle(20);                       // R6 clear
        for (int i = 0; i < 20; i++) wr(0, 3, 1);                // R6 set beats clear
        wr(0, 3, 0); idle(10);
        req = "R3"; wr(1, 2, 3); wr(1, 0, 16'h8034); idle(100);  // R3 divide by 8
        wr(0, 2, 2); wr(0, 0, 16'h8070); wr(0, 1, 0); idle(800); // R3 divide by 256
        wr(0, 0, 16'h8050); idle(200);                           // R3 divide by 32
        req = "R4"; wr(0, 0, 16'h0050); idle(40); wr(0, 0, 16'h8050); idle(30); // R4
        req = "R5"; wr(1, 0, 0); wr(1, 2, 4); wr(1, 1, 0); wr(1, 3, 1);
        wr(1, 0, 16'h8006); ext_pulses(1, 12, 3, 3); ext_pulses(1, 2, 20, 2); // R5
        req = "R9"; wr(0, 0, 16'h8010); wr(0, 2, 100);
        for (int i = 0; i < 10; i++) begin wr(0, 1, 90 + i); idle(1); end     // R9
        idle(30);
        req = "R8"; wr(0, 0, 0); wr(1, 0, 0);
        wr(0, 3, 1); wr(1, 3, 1);
        wr(0, 1, 16'hFFF0); wr(1, 1, 0); wr(0, 2, 5); wr(1, 2, 1);
        wr(1, 0, 16'h8004); wr(0, 0, 16'h800C); idle(60);                     // R8
        wr(1, 3, 1); wr(0, 1, 16'hFFFA); wr(0, 0, 16'h802C); idle(150);
        wr(1, 3, 1); wr(1, 1, 1); wr(0, 1, 0); wr(0, 0, 16'h800E);
        fork
            ext_pulses(0, 10, 2, 3);
            ext_pulses(1, 10, 3, 2);
        join
        idle(10);
        wr(1, 1, 0); idle(10);                                   // R9 upper-half write
        req = "R10"; wr(0, 0, 0); wr(1, 0, 16'hFFFF); wr(0, 0, 16'hFFF7); idle(24); // R10
        wr(1, 0, 0); wr(0, 0, 16'h8000); idle(20);
        finish_run();
    end

endmodule